// File: doc/BRIEF.md
# Dual Adjacent-Channel Window Watchdog

This block watches the stream of conversion results that a successive-approximation converter writes out, one channel at a time. A single base-channel field selects a pair of neighbouring channels. Watchdog A checks results for the base channel. Watchdog B checks results for the channel just above it. Each watchdog compares the incoming result against its own upper and lower limits. When a result falls outside its window, the block latches a flag and raises an interrupt request.

The four flags are sticky. Software clears them by writing a one-hot or multi-bit clear mask. The interrupt request is the OR of the latched flags, gated by an enable input. Threshold values, the base channel and the enable are plain configuration inputs that are held stable by the surrounding register file.

Top module: `adc_window_watch`

## Requirements
- R1: Watchdog A evaluates a result only on a cycle where `res_valid` is 1 and `res_chan` equals `base_chan`.
- R2: Watchdog B evaluates a result only when `res_valid` is 1 and `res_chan` equals `base_chan`+1. When `base_chan` is 15 (all ones), B never evaluates: the channel number does not wrap to 0.
- R3: A result strictly greater than the upper limit sets the "above" flag: `flags[0]` for A, `flags[2]` for B.
- R4: A result strictly less than the lower limit sets the "below" flag: `flags[1]` for A, `flags[3]` for B.
- R5: A result equal to either limit, or inside the window, sets no flag.
- R6: A result presented with `res_valid` at 0, or for a channel outside the monitored pair, leaves all flags unchanged.
- R7: A flag becomes visible on `flags` at the first rising clock edge after the qualifying result. It then stays set until it is cleared.
- R8: When `clr_valid` is 1, each flag whose `clr_mask` bit is 1 is cleared at the next edge. Flags whose mask bit is 0 keep their value.
- R9: If a flag is set and cleared in the same cycle, the set wins and the flag reads 1 afterwards.
- R10: `irq` is 1 exactly when `irq_en` is 1 and at least one flag is set. It follows `flags` without an extra cycle of delay.
- R11: While `rst_n` is low, all flags are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Strobe: a conversion result is being written this cycle |
| res_chan | input | 4 | Channel number of the result |
| res_data | input | 10 | Result value |
| base_chan | input | 4 | First channel of the monitored pair (watchdog A) |
| a_hi | input | 10 | Upper limit for watchdog A |
| a_lo | input | 10 | Lower limit for watchdog A |
| b_hi | input | 10 | Upper limit for watchdog B |
| b_lo | input | 10 | Lower limit for watchdog B |
| irq_en | input | 1 | Interrupt enable |
| clr_valid | input | 1 | Strobe for a flag clear |
| clr_mask | input | 4 | Flags to clear: bit0 A above, bit1 A below, bit2 B above, bit3 B below |
| flags | output | 4 | Sticky compare flags, same bit order as `clr_mask` |
| irq | output | 1 | Interrupt request |

## Verification
A new out-of-window result can arrive on the same cycle in which software clears the flag that this result sets. The bench first latches the B-below flag. Then, on one cycle, it drives a below-window result for the B channel together with a clear mask that covers that same bit. It then checks that the flag still reads 1 after the edge. A second case checks that a clear of one flag does not disturb another flag that stays latched.

// File: rtl/awd_pkg.sv
package awd_pkg;
   localparam int FLAG_N   = 4;
   localparam int WDOG_N   = 2;

   // flag bit positions, also the clear-mask bit positions
   localparam int F_A_HI = 0;
   localparam int F_A_LO = 1;
   localparam int F_B_HI = 2;
   localparam int F_B_LO = 3;

   typedef struct packed {
      logic hi;
      logic lo;
   } win_hit_t;
endpackage

// File: rtl/awd_chan_match.sv
module awd_chan_match #(
   parameter int CH_W = 4
) (
   input  logic            res_valid,
   input  logic [CH_W-1:0] res_chan,
   input  logic [CH_W-1:0] base_chan,
   output logic            hit_a,
   output logic            hit_b
);
   localparam logic [CH_W-1:0] TOP_CH = {CH_W{1'b1}};
   localparam logic [CH_W-1:0] ONE_CH = CH_W'(1);

   logic [CH_W-1:0] next_chan;
   logic            b_allowed;

   generate
      if (CH_W < 1) begin : g_bad_width
         $error("awd_chan_match: CH_W must be at least 1");
      end
   endgenerate

   always_comb begin
      next_chan = base_chan + ONE_CH;
      b_allowed = (base_chan != TOP_CH);
      hit_a     = res_valid && (res_chan == base_chan);
      hit_b     = res_valid && b_allowed && (res_chan == next_chan);
   end
endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp
   import awd_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              enable,
   input  logic [DATA_W-1:0] sample,
   input  logic [DATA_W-1:0] lim_hi,
   input  logic [DATA_W-1:0] lim_lo,
   output win_hit_t          hit
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("awd_window_cmp: DATA_W must be at least 2");
      end
   endgenerate

   logic above;
   logic below;

   always_comb begin
      above  = (sample > lim_hi);
      below  = (sample < lim_lo);
      hit.hi = enable && above;
      hit.lo = enable && below;
   end
endmodule

// File: rtl/awd_flag_bank.sv
module awd_flag_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         clr_valid,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] state
);
   generate
      if (N < 1) begin : g_bad_n
         $error("awd_flag_bank: N must be at least 1");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_bit
         logic kill;
         assign kill = clr_valid && clr_mask[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          state[i] <= 1'b0;
            else if (set_vec[i]) state[i] <= 1'b1;   // set beats clear
            else if (kill)       state[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch
   import awd_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int CH_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [CH_W-1:0]   res_chan,
   input  logic [DATA_W-1:0] res_data,
   input  logic [CH_W-1:0]   base_chan,
   input  logic [DATA_W-1:0] a_hi,
   input  logic [DATA_W-1:0] a_lo,
   input  logic [DATA_W-1:0] b_hi,
   input  logic [DATA_W-1:0] b_lo,
   input  logic              irq_en,
   input  logic              clr_valid,
   input  logic [FLAG_N-1:0] clr_mask,
   output logic [FLAG_N-1:0] flags,
   output logic              irq
);
   localparam int NUM_CH = 1 << CH_W;

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("adc_window_watch: need at least two channels");
      end
      if (FLAG_N != 2 * WDOG_N) begin : g_bad_flags
         $error("adc_window_watch: flag count must be two per watchdog");
      end
   endgenerate

   logic [WDOG_N-1:0]              hit_w;
   logic [WDOG_N-1:0][DATA_W-1:0]  lim_hi_w;
   logic [WDOG_N-1:0][DATA_W-1:0]  lim_lo_w;
   win_hit_t [WDOG_N-1:0]          win_w;
   logic [FLAG_N-1:0]              set_vec;

   assign lim_hi_w[0] = a_hi;
   assign lim_lo_w[0] = a_lo;
   assign lim_hi_w[1] = b_hi;
   assign lim_lo_w[1] = b_lo;

   awd_chan_match #(.CH_W(CH_W)) match_i (
      .res_valid (res_valid),
      .res_chan  (res_chan),
      .base_chan (base_chan),
      .hit_a     (hit_w[0]),
      .hit_b     (hit_w[1])
   );

   genvar w;
   generate
      for (w = 0; w < WDOG_N; w++) begin : g_wdog
         awd_window_cmp #(.DATA_W(DATA_W)) cmp_i (
            .enable (hit_w[w]),
            .sample (res_data),
            .lim_hi (lim_hi_w[w]),
            .lim_lo (lim_lo_w[w]),
            .hit    (win_w[w])
         );
         assign set_vec[2*w]   = win_w[w].hi;
         assign set_vec[2*w+1] = win_w[w].lo;
      end
   endgenerate

   awd_flag_bank #(.N(FLAG_N)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec),
      .clr_valid (clr_valid),
      .clr_mask  (clr_mask),
      .state     (flags)
   );

   assign irq = irq_en && (|flags);
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
   parameter int DATA_W = 10,
   parameter int CH_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              res_valid,
   input logic [CH_W-1:0]   res_chan,
   input logic [DATA_W-1:0] res_data,
   input logic [CH_W-1:0]   base_chan,
   input logic [DATA_W-1:0] a_hi,
   input logic [DATA_W-1:0] a_lo,
   input logic              irq_en,
   input logic              clr_valid,
   input logic [3:0]        clr_mask,
   input logic [3:0]        flags,
   input logic              irq
);
   a_r3_a_above_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_chan == base_chan && res_data > a_hi) |=> flags[0]);

   a_r4_a_below_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_chan == base_chan && res_data < a_lo) |=> flags[1]);

   a_r2_b_silent_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (base_chan == {CH_W{1'b1}} && flags[3:2] == 2'b00) |=> flags[3:2] == 2'b00);

   a_r6_no_strobe_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_valid && flags == 4'b0000) |=> flags == 4'b0000);

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !(clr_valid && clr_mask[0])) |=> flags[0]);

   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_valid && clr_mask[1] && !res_valid) |=> !flags[1]);

   a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == 4'b0000) |-> !irq);
endmodule

bind adc_window_watch awd_checker #(.DATA_W(DATA_W), .CH_W(CH_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
   .res_data(res_data), .base_chan(base_chan), .a_hi(a_hi), .a_lo(a_lo),
   .irq_en(irq_en), .clr_valid(clr_valid), .clr_mask(clr_mask),
   .flags(flags), .irq(irq)
);

// File: tb/adc_window_watch_tb_top.sv
module adc_window_watch_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       res_valid = 1'b0;
   logic [3:0] res_chan = '0;
   logic [9:0] res_data = '0;
   logic [3:0] base_chan = 4'd4;
   logic [9:0] a_hi = 10'd600, a_lo = 10'd200, b_hi = 10'd800, b_lo = 10'd100;
   logic       irq_en = 1'b1;
   logic       clr_valid = 1'b0;
   logic [3:0] clr_mask = '0;
   logic [3:0] flags;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_window_watch dut_i (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
      .res_data(res_data), .base_chan(base_chan), .a_hi(a_hi), .a_lo(a_lo),
      .b_hi(b_hi), .b_lo(b_lo), .irq_en(irq_en), .clr_valid(clr_valid),
      .clr_mask(clr_mask), .flags(flags), .irq(irq)
   );

   task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   // one cycle of stimulus, driven at a falling edge; outputs sampled at the next falling edge
   task automatic step(input logic v, input logic [3:0] ch, input logic [9:0] d,
                       input logic cv, input logic [3:0] cm);
      @(negedge clk);
      res_valid = v; res_chan = ch; res_data = d; clr_valid = cv; clr_mask = cm;
      @(negedge clk);
      res_valid = 1'b0; clr_valid = 1'b0; clr_mask = '0;
   endtask

   task automatic clear_all();
      step(1'b0, 4'd0, 10'd0, 1'b1, 4'b1111);
   endtask

   task automatic t_reset();
      check("R11 flags in reset", flags, 4'b0000);
      check("R11 irq in reset", {3'b0, irq}, 4'b0000);
   endtask

   task automatic t_above_a();
      step(1'b1, 4'd4, 10'd601, 1'b0, 4'b0);
      check("R1 R3 A above", flags, 4'b0001);
      check("R10 irq with flag", {3'b0, irq}, 4'b0001);
      clear_all();
      check("R8 clear all", flags, 4'b0000);
   endtask

   task automatic t_below_b();
      step(1'b1, 4'd5, 10'd99, 1'b0, 4'b0);
      check("R2 R4 B below", flags, 4'b1000);
      clear_all();
   endtask

   task automatic t_equal();
      step(1'b1, 4'd4, 10'd600, 1'b0, 4'b0);
      step(1'b1, 4'd4, 10'd200, 1'b0, 4'b0);
      step(1'b1, 4'd5, 10'd800, 1'b0, 4'b0);
      step(1'b1, 4'd5, 10'd100, 1'b0, 4'b0);
      check("R5 equal limits", flags, 4'b0000);
      check("R10 no irq without flag", {3'b0, irq}, 4'b0000);
   endtask

   task automatic t_ignore();
      step(1'b0, 4'd4, 10'd1000, 1'b0, 4'b0);
      check("R6 no strobe", flags, 4'b0000);
      step(1'b1, 4'd6, 10'd1000, 1'b0, 4'b0);
      step(1'b1, 4'd3, 10'd0, 1'b0, 4'b0);
      check("R6 other channels", flags, 4'b0000);
   endtask

   task automatic t_sticky();
      step(1'b1, 4'd4, 10'd5, 1'b0, 4'b0);
      check("R4 A below", flags, 4'b0010);
      step(1'b1, 4'd4, 10'd400, 1'b0, 4'b0);
      check("R7 sticky in window", flags, 4'b0010);
      irq_en = 1'b0;
      #1;
      check("R10 irq gated off", {3'b0, irq}, 4'b0000);
      irq_en = 1'b1;
      #1;
      check("R10 irq enabled", {3'b0, irq}, 4'b0001);
      clear_all();
   endtask

   task automatic t_partial_clear();
      step(1'b1, 4'd4, 10'd700, 1'b0, 4'b0);
      step(1'b1, 4'd5, 10'd20, 1'b0, 4'b0);
      check("R3 R4 two flags", flags, 4'b1001);
      step(1'b0, 4'd0, 10'd0, 1'b1, 4'b0001);
      check("R8 partial clear", flags, 4'b1000);
   endtask

   task automatic t_same_cycle();
      step(1'b1, 4'd5, 10'd50, 1'b1, 4'b1000);
      check("R9 set beats clear", flags, 4'b1000);
      step(1'b1, 4'd5, 10'd900, 1'b1, 4'b1000);
      check("R9 other bit set while clearing", flags, 4'b0100);
      clear_all();
   endtask

   task automatic t_top_chan();
      base_chan = 4'd15;
      step(1'b1, 4'd15, 10'd700, 1'b0, 4'b0);
      check("R1 A at top channel", flags, 4'b0001);
      step(1'b1, 4'd0, 10'd1000, 1'b0, 4'b0);
      step(1'b1, 4'd0, 10'd0, 1'b0, 4'b0);
      check("R2 B disabled, no wrap", flags, 4'b0001);
      clear_all();
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_above_a();
      t_below_b();
      t_equal();
      t_ignore();
      t_sticky();
      t_partial_clear();
      t_same_cycle();
      t_top_chan();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule